// File: doc/BRIEF.md
# Serial Byte Shifter with Acknowledge Stage for an I2C Controller

This block is the byte datapath of a two-wire (I2C) controller. A data register and a hidden acknowledge flag are chained into one shift path one bit longer than the byte. Bits sampled from the serial data line enter at the acknowledge end on rising clock strobes. The most significant bit leaves first, through a one-bit drive buffer that updates on falling clock strobes. The same register both sends and receives. After a byte has gone out, it therefore holds what was actually seen on the wire, which is the data a master needs when it loses arbitration part-way through a byte and turns into a receiver.

The surrounding controller supplies single-cycle strobes for the rising and falling edges of the serial clock, and the level sensed on the data line. It also supplies a hold signal that is high while the serial interrupt flag is set. While hold is high, the shift path is frozen and the processor may load or read the byte. A load made while hold is low is dropped and recorded in a sticky error flag. Once the acknowledge slot has been sampled, the received acknowledge bit is presented on a status output. To receive a byte, the processor loads all ones so that the block leaves the line released.

Top module: `i2cb_byte_shifter`

## Requirements
- R1: After reset, `cpu_rdata` is 0, `sda_drv` is 1 (line released), and `ack_valid`, `ack_rx` and `wr_err` are 0.
- R2: A `scl_rise` strobe while `xfer_hold` is 0 shifts the chain left by one. The value of `sda_in` enters the acknowledge flag, and the flag's old value enters bit 0 of the data register. After nine such strobes, the first sampled bit sits in bit 7 of `cpu_rdata` and the ninth sits in the acknowledge flag.
- R3: A `cpu_wr` while `xfer_hold` is 1 loads `cpu_wdata` into the data register. In the next cycle, `sda_drv` equals `cpu_wdata[7]`. The load restarts the bit count of the byte.
- R4: After a `scl_fall` strobe while `xfer_hold` is 0, `sda_drv` takes one of four values. It holds its value if no rising strobe has occurred since the load. After k rising strobes, with k from 1 to 7, it equals bit 7-k of the loaded byte. After eight, it equals the `ack_slot` input. After nine, it is 1.
- R5: While `xfer_hold` is 1, `scl_rise` and `scl_fall` strobes change neither `cpu_rdata`, `sda_drv` nor `ack_valid`.
- R6: A `cpu_wr` while `xfer_hold` is 0 leaves `cpu_rdata` and `sda_drv` unchanged and sets `wr_err` in the next cycle.
- R7: `wr_err` stays 1 until reset, including across later accepted writes.
- R8: `ack_valid` rises in the cycle after the ninth rising strobe of a byte, and `ack_rx` then shows the ninth sampled bit. Both return to 0 after the next rising strobe or the next accepted write. Before the ninth rising strobe, `ack_valid` is 0.
- R9: When the bus is the wired AND of `sda_drv` and another sender's bits, the data register holds the AND of the sent byte and the other byte once the byte has finished.
- R10: `cpu_rdata` changes only after an accepted write or a rising strobe while `xfer_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_hold | input | 1 | High while the serial interrupt flag is set; freezes shifting and allows processor access |
| cpu_wr | input | 1 | Processor write strobe for the data byte |
| cpu_wdata | input | 8 | Byte written by the processor |
| cpu_rdata | output | 8 | Current data register contents |
| scl_rise | input | 1 | One-cycle strobe for a rising serial clock edge |
| scl_fall | input | 1 | One-cycle strobe for a falling serial clock edge |
| sda_in | input | 1 | Sensed serial data line level |
| ack_slot | input | 1 | Level to drive during the acknowledge clock, supplied by the controller |
| sda_drv | output | 1 | Data line drive level, 0 pulls low and 1 releases |
| ack_valid | output | 1 | High once the acknowledge bit of the byte has been sampled |
| ack_rx | output | 1 | Received acknowledge bit, valid while ack_valid is high |
| wr_err | output | 1 | Sticky flag for a write made while shifting |

## Verification
The bench sends every byte value twice over a wired-AND loopback: once against a released line, and once against a competing sender whose byte changes with each pass. It checks the drive level before each of the nine sampling strobes and the byte read back afterwards. A design with the chain off by one, or shifting in the wrong direction, would return a rotated byte or lose the last data bit into the acknowledge flag. A buffer that took its value from the received bit instead of the stored one would keep driving the other sender's pattern after arbitration was lost. The bench also confirms that the acknowledge status shows only after the ninth strobe and goes away on wrap-around. It checks that strobes during hold are dropped, and that an illegal load is dropped while the error flag stays set. Getting any of these wrong would show as corrupted bytes or a flag that clears itself.

// File: rtl/i2cb_pkg.sv
// Package: shared types and helpers for the I2C byte shifter.
// Assumes the chain is one data byte (parameterised) plus one acknowledge bit.
package i2cb_pkg;

    // Source selected for the drive buffer on a falling clock strobe
    typedef enum logic [1:0] {
        SRC_KEEP    = 2'd0,
        SRC_DATA    = 2'd1,
        SRC_ACK     = 2'd2,
        SRC_RELEASE = 2'd3
    } buf_src_e;

    // Picks the buffer source from the number of rising strobes seen in this byte
    function automatic buf_src_e pick_src(input int unsigned rises, input int unsigned width);
        if (rises == 0)
            return SRC_KEEP;
        else if (rises < width)
            return SRC_DATA;
        else if (rises == width)
            return SRC_ACK;
        else
            return SRC_RELEASE;
    endfunction

endpackage

// File: rtl/i2cb_cpu_gate.sv
// Module: processor access gate.
// Accepts a byte load only while the shift path is frozen (hold high).
// A load attempted while shifting is dropped and latches a sticky error flag.
module i2cb_cpu_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_hold,
    input  logic cpu_wr,
    output logic load_ok,
    output logic wr_err
);

    // Accepted load strobe
    always_comb begin
        load_ok = cpu_wr & xfer_hold;
    end

    // Sticky record of a load made during shifting
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_err <= 1'b0;
        else if (cpu_wr && !xfer_hold)
            wr_err <= 1'b1;
    end

endmodule

// File: rtl/i2cb_shift_chain.sv
// Module: data register plus acknowledge flag, one shift chain of DATA_W+1 bits.
// Shifts left on an enabled rising strobe, taking the line level at the
// acknowledge end. Counts rising strobes per byte; the count restarts on a
// load and wraps from the last slot back to the first bit of a new byte.
module i2cb_shift_chain #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    input  logic              line_bit,
    output logic [DATA_W-1:0] data_q,
    output logic              ack_q,
    output logic [CNT_W-1:0]  rises_q
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1);

    logic [CNT_W-1:0] rises_nxt;

    // Next strobe count, wrapping after the acknowledge slot
    always_comb begin
        if (rises_q == LAST_SLOT)
            rises_nxt = FIRST_BIT;
        else
            rises_nxt = rises_q + FIRST_BIT;
    end

    // Data register: loaded by the processor or shifted through the acknowledge flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (load)
            data_q <= load_data;
        else if (shift)
            data_q <= {data_q[DATA_W-2:0], ack_q};
    end

    // Acknowledge flag: hidden tail of the chain, fed from the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (shift && !load)
            ack_q <= line_bit;
    end

    // Rising strobe count of the current byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            rises_q <= '0;
        else if (load)
            rises_q <= '0;
        else if (shift)
            rises_q <= rises_nxt;
    end

endmodule

// File: rtl/i2cb_drive_buf.sv
// Module: one-bit drive buffer for the serial data line.
// Loaded from the top data bit when the processor loads a byte; on each enabled
// falling strobe it takes the next outgoing bit, the acknowledge drive level or
// the released level, depending on how many rising strobes the byte has seen.
module i2cb_drive_buf
    import i2cb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_bit,
    input  logic             advance,
    input  logic [CNT_W-1:0] rises,
    input  logic             data_msb,
    input  logic             ack_slot,
    output logic             drv_q
);

    buf_src_e src;

    // Selects what the next falling strobe puts on the line
    always_comb begin
        src = pick_src(int'(rises), DATA_W);
    end

    // Drive buffer register, released (1) after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_q <= 1'b1;
        else if (load)
            drv_q <= load_bit;
        else if (advance) begin
            case (src)
                SRC_DATA:    drv_q <= data_msb;
                SRC_ACK:     drv_q <= ack_slot;
                SRC_RELEASE: drv_q <= 1'b1;
                default:     drv_q <= drv_q;
            endcase
        end
    end

endmodule

// File: rtl/i2cb_byte_shifter.sv
// Module: top of the I2C byte datapath.
// Combines the processor gate, the DATA_W+1 bit shift chain and the drive buffer.
// Assumes single-cycle edge strobes that are never both high in one cycle, and a
// hold input that is high exactly while the serial interrupt flag is set.
module i2cb_byte_shifter #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_hold,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              ack_slot,
    output logic              sda_drv,
    output logic              ack_valid,
    output logic              ack_rx,
    output logic              wr_err
);

    localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(DATA_W + 1);

    logic             load_ok;
    logic             shift_en;
    logic             fall_en;
    logic [DATA_W-1:0] data_q;
    logic             ack_q;
    logic [CNT_W-1:0] rises_q;

    // Strobes are honoured only while the path is not frozen
    always_comb begin
        shift_en = scl_rise & ~xfer_hold;
        fall_en  = scl_fall & ~xfer_hold;
    end

    i2cb_cpu_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_hold (xfer_hold),
        .cpu_wr    (cpu_wr),
        .load_ok   (load_ok),
        .wr_err    (wr_err)
    );

    i2cb_shift_chain #(.DATA_W(DATA_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .load_data (cpu_wdata),
        .shift     (shift_en),
        .line_bit  (sda_in),
        .data_q    (data_q),
        .ack_q     (ack_q),
        .rises_q   (rises_q)
    );

    i2cb_drive_buf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_bit (cpu_wdata[DATA_W-1]),
        .advance  (fall_en),
        .rises    (rises_q),
        .data_msb (data_q[DATA_W-1]),
        .ack_slot (ack_slot),
        .drv_q    (sda_drv)
    );

    // Status outputs: byte readback and received acknowledge once sampled
    always_comb begin
        cpu_rdata = data_q;
        ack_valid = (rises_q == DONE_CNT);
        ack_rx    = ack_q & ack_valid;
    end

endmodule

// File: rtl/i2cb_byte_shifter_chk.sv
// Module: assertion checker for the byte shifter, bound to the top module.
// Observes ports only.
module i2cb_byte_shifter_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_hold,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              sda_drv,
    input logic              ack_valid,
    input logic              wr_err
);

    a_r3_load_sets_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && xfer_hold) |=> (sda_drv == $past(cpu_wdata[DATA_W-1])));

    a_r3_load_sets_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && xfer_hold) |=> (cpu_rdata == $past(cpu_wdata)));

    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_hold && !cpu_wr) |=> ($stable(cpu_rdata) && $stable(sda_drv) && $stable(ack_valid)));

    a_r6_bad_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !xfer_hold) |=> wr_err);

    a_r6_bad_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !xfer_hold && !scl_rise && !scl_fall) |=> ($stable(cpu_rdata) && $stable(sda_drv)));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    a_r4_drive_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !cpu_wr) |=> $stable(sda_drv));

    a_r10_data_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise && !cpu_wr) |=> $stable(cpu_rdata));

endmodule

bind i2cb_byte_shifter i2cb_byte_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_hold (xfer_hold),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_drv   (sda_drv),
    .ack_valid (ack_valid),
    .wr_err    (wr_err)
);

// File: tb/i2cb_byte_shifter_tb.sv
// Bench: wired-AND loopback sweep over all byte values, plus hold, wrap and
// illegal-write cases. Expected values are computed from the requirements.
module i2cb_byte_shifter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_hold = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       scl_rise = 1'b0;
    logic       scl_fall = 1'b0;
    logic       sda_in = 1'b1;
    logic       ack_slot = 1'b1;
    logic       sda_drv;
    logic       ack_valid;
    logic       ack_rx;
    logic       wr_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2cb_byte_shifter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_hold (xfer_hold),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .ack_slot  (ack_slot),
        .sda_drv   (sda_drv),
        .ack_valid (ack_valid),
        .ack_rx    (ack_rx),
        .wr_err    (wr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_load(input logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_rise();
        @(negedge clk);
        scl_rise = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        @(negedge clk);
        scl_fall = 1'b1;
        @(negedge clk);
        scl_fall = 1'b0;
    endtask

    // One byte over a wired-AND bus against another sender's byte and ack bit
    task automatic run_byte(input logic [7:0] b, input logic [7:0] other,
                            input logic aslot, input logic peer_ack);
        logic [7:0] recv;
        logic       bus_ack;
        recv = b & other;
        bus_ack = aslot & peer_ack;
        xfer_hold = 1'b1;
        ack_slot = aslot;
        cpu_load(b);
        chk("R3 drive after load", 32'(sda_drv), 32'(b[7]));
        chk("R8 ack_valid cleared by load", 32'(ack_valid), 32'h0);
        xfer_hold = 1'b0;
        pulse_fall();
        chk("R4 fall before first rise keeps drive", 32'(sda_drv), 32'(b[7]));
        for (int k = 0; k < 9; k++) begin
            if (k < 8) begin
                chk("R4 data bit on line", 32'(sda_drv), 32'(b[7-k]));
                sda_in = sda_drv & other[7-k];
            end else begin
                chk("R4 ack slot on line", 32'(sda_drv), 32'(aslot));
                sda_in = sda_drv & peer_ack;
            end
            pulse_rise();
            if (k == 7)
                chk("R8 no ack_valid before ninth rise", 32'(ack_valid), 32'h0);
            pulse_fall();
        end
        chk("R4 released after ninth", 32'(sda_drv), 32'h1);
        chk("R9 readback is bus byte", 32'(cpu_rdata), 32'(recv));
        chk("R8 ack_valid after ninth rise", 32'(ack_valid), 32'h1);
        chk("R8 ack_rx is ninth bit", 32'(ack_rx), 32'(bus_ack));
        chk("R2 first sampled bit in bit 7", 32'(cpu_rdata[7]), 32'(recv[7]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        logic       snap_drv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", 32'(cpu_rdata), 32'h0);
        chk("R1 sda_drv", 32'(sda_drv), 32'h1);
        chk("R1 ack_valid", 32'(ack_valid), 32'h0);
        chk("R1 ack_rx", 32'(ack_rx), 32'h0);
        chk("R1 wr_err", 32'(wr_err), 32'h0);

        // Released peer: plain transmit, readback equals sent byte
        for (int b = 0; b < 256; b++)
            run_byte(8'(b), 8'hFF, b[0], 1'b1);
        // Competing peer: arbitration loss mid-byte, readback is the wired AND
        for (int b = 0; b < 256; b++)
            run_byte(8'(b), 8'(b * 37 + 11), b[2], b[5]);

        // Receive: processor loads all ones, peer byte arrives
        run_byte(8'hFF, 8'h6C, 1'b0, 1'b1);
        chk("R9 received byte", 32'(cpu_rdata), 32'h6C);

        // Hold freezes strobes
        xfer_hold = 1'b1;
        snap = cpu_rdata;
        snap_drv = sda_drv;
        sda_in = 1'b0;
        pulse_rise();
        pulse_fall();
        chk("R5 rdata frozen", 32'(cpu_rdata), 32'(snap));
        chk("R5 drive frozen", 32'(sda_drv), 32'(snap_drv));
        chk("R5 ack_valid frozen", 32'(ack_valid), 32'h1);
        chk("R10 no change without rise", 32'(cpu_rdata), 32'(snap));

        // Wrap: rise after the ack slot starts a new byte
        xfer_hold = 1'b0;
        sda_in = 1'b1;
        pulse_rise();
        chk("R8 ack_valid drops on wrap", 32'(ack_valid), 32'h0);
        chk("R8 ack_rx drops on wrap", 32'(ack_rx), 32'h0);
        chk("R2 shift after wrap", 32'(cpu_rdata), 32'({snap[6:0], 1'b0}));

        // Illegal load while shifting
        snap = cpu_rdata;
        snap_drv = sda_drv;
        chk("R7 wr_err clear before", 32'(wr_err), 32'h0);
        cpu_load(~snap);
        chk("R6 rdata unchanged", 32'(cpu_rdata), 32'(snap));
        chk("R6 drive unchanged", 32'(sda_drv), 32'(snap_drv));
        chk("R6 wr_err set", 32'(wr_err), 32'h1);

        // Legal load afterwards; flag persists
        xfer_hold = 1'b1;
        cpu_load(8'h3C);
        chk("R3 legal load data", 32'(cpu_rdata), 32'h3C);
        chk("R3 legal load drive", 32'(sda_drv), 32'h0);
        chk("R7 wr_err sticky", 32'(wr_err), 32'h1);
        repeat (4) @(negedge clk);
        chk("R7 wr_err still set", 32'(wr_err), 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule